// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Butterfly with Scaling

This block is one butterfly of a pipelined fixed-point FFT that uses the decimation-in-frequency split. Each cycle it can take two complex operands A and B and an index into its own twiddle table. It returns two complex results. The upper result is A+B. The lower result is (A−B)·W, where W is the twiddle factor picked by the index. The complex product takes three real multipliers, not four, because the real and imaginary parts share one partial product.

A shift right by one can be applied after the butterfly, so that the words of a multi-stage FFT do not grow without bound. A parameter sets this shift to always off, always on, or taken from a per-sample input. Every result is then reduced to the output width with round-half-to-even. This keeps the rounding error free of bias, whatever the sign of the data. Both results leave the block on the same cycle, four clock edges after their operands, together with a valid flag. The surrounding FFT owns the operand ordering, the choice of twiddle index and any reordering of the output.

Top module: `bfly_dif_r2`

## Requirements
- R1: The upper output equals round(A+B / 2^s) on each of the real and imaginary lanes, where s is 1 when scaling is active for that sample and 0 otherwise.
- R2: The lower output equals round(Re((A−B)·W_k) / 2^(F+s)) for the real lane and round(Im((A−B)·W_k) / 2^(F+s)) for the imaginary lane. Here F = TW−2, and W_k = C_k + jS_k uses the integer table values of R3.
- R3: The twiddle table has NPTS/2 entries, addressed by tw_addr = k. C_k = round(cos(2πk/NPTS)·2^F) and S_k = −round(sin(2πk/NPTS)·2^F), each TW bits signed, with ties rounded away from zero.
- R4: With tw_addr = 0 the twiddle is exactly 1 (C=2^F, S=0), so the lower output equals A−B after the scaling shift and rounding only.
- R5: SCALE_MODE selects the scaling. SCL_OFF never shifts. SCL_ON always shifts by one. SCL_PORT (the default) shifts when scale_in is 1, sampled in the same cycle as the operands.
- R6: The rounding is round-half-to-even. With a shift of one, the upper real lane maps 1→0, 3→2, 5→2, 7→4, −1→0, −3→−2 and −5→−2.
- R7: out_valid equals in_valid delayed by four clock edges. The data on the outputs belongs to the operands that were presented with that in_valid.
- R8: While rst_n is low, out_valid and all four data outputs are 0.
- R9: Outputs are DW+2 bits signed and never wrap for any operand values, including full-scale operands at the 45-degree twiddle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle are valid |
| a_re | input | DW | Operand A, real part, signed |
| a_im | input | DW | Operand A, imaginary part, signed |
| b_re | input | DW | Operand B, real part, signed |
| b_im | input | DW | Operand B, imaginary part, signed |
| tw_addr | input | log2(NPTS/2) | Twiddle table index k |
| scale_in | input | 1 | Requests the shift by one (used in SCL_PORT mode) |
| out_valid | output | 1 | Results on this cycle are valid |
| up_re | output | DW+2 | Upper result A+B, real part |
| up_im | output | DW+2 | Upper result A+B, imaginary part |
| lo_re | output | DW+2 | Lower result (A−B)·W, real part |
| lo_im | output | DW+2 | Lower result (A−B)·W, imaginary part |

## Verification
The hardest case to reach from the ports is an exact rounding tie on the lower path. Random operands with general twiddles almost never leave a remainder of exactly one half after the product is shifted down by F+1 bits. The stimulus forces such ties with tw_addr 0 and tw_addr NPTS/4, where the product is a pure power-of-two multiple of one lane of A−B, and combines them with odd differences and the shift enabled. On the upper path, ties come from directed odd sums with scaling on. Full-scale operand pairs at the 45-degree entry drive the lower outputs to their largest magnitude.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic [1:0] {
    SCL_OFF  = 2'd0,
    SCL_ON   = 2'd1,
    SCL_PORT = 2'd2
  } scale_mode_e;

  // pi in Q2.30 fixed point
  localparam longint PI_Q30 = 64'sd3373259426;

  // cos or sin of 2*pi*k/n in Q30, by power series on a reduced angle
  function automatic longint trig_q30(input int k, input int n, input bit want_sin);
    longint th;
    longint th2;
    longint term;
    longint acc;
    int     kk;
    bit     flip;
    kk   = k;
    flip = 1'b0;
    if (4 * k > n) begin
      kk   = n / 2 - k;
      flip = !want_sin;
    end
    th   = (PI_Q30 * 2 * longint'(kk)) / longint'(n);
    th2  = (th * th) >>> 30;
    term = want_sin ? th : (64'sd1 <<< 30);
    acc  = term;
    for (int i = 1; i <= 12; i++) begin
      if (want_sin)
        term = -((term * th2) >>> 30) / longint'((2 * i) * (2 * i + 1));
      else
        term = -((term * th2) >>> 30) / longint'((2 * i - 1) * (2 * i));
      acc = acc + term;
    end
    return flip ? -acc : acc;
  endfunction

  // Q30 value to frac fraction bits, ties away from zero
  function automatic longint tw_quant(input longint a, input int frac);
    longint mag;
    longint r;
    mag = (a < 0) ? -a : a;
    r   = (mag + (64'sd1 <<< (29 - frac))) >>> (30 - frac);
    return (a < 0) ? -r : r;
  endfunction

endpackage

// File: rtl/bfly_twiddle_rom.sv
module bfly_twiddle_rom #(
  parameter int NPTS = 16,
  parameter int TW   = 16,
  localparam int DEPTH = NPTS / 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  output logic signed [TW-1:0] c_o,
  output logic signed [TW-1:0] s_o
);
  import bfly_pkg::*;

  localparam int FRAC = TW - 2;

  logic signed [TW-1:0] c_tab [DEPTH];
  logic signed [TW-1:0] s_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam longint CV = tw_quant(trig_q30(g, NPTS, 1'b0), FRAC);
    localparam longint SV = -tw_quant(trig_q30(g, NPTS, 1'b1), FRAC);
    assign c_tab[g] = TW'(CV);
    assign s_tab[g] = TW'(SV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_o <= '0;
      s_o <= '0;
    end else begin
      c_o <= c_tab[addr];
      s_o <= s_tab[addr];
    end
  end

endmodule

// File: rtl/bfly_cmul3.sv
module bfly_cmul3 #(
  parameter int XW = 13,
  parameter int TW = 16,
  localparam int MW = XW + TW + 1,
  localparam int PW = XW + TW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [TW-1:0] c_i,
  input  logic signed [TW-1:0] s_i,
  output logic                 v_o,
  output logic signed [PW-1:0] re_o,
  output logic signed [PW-1:0] im_o
);

  function automatic logic signed [MW-1:0] smul(input logic signed [MW-1:0] p,
                                                input logic signed [MW-1:0] q);
    return p * q;
  endfunction

  logic signed [XW:0]   x_minus_y;
  logic signed [TW:0]   c_minus_s;
  logic signed [TW:0]   c_plus_s;
  logic signed [MW-1:0] z_q;
  logic signed [MW-1:0] pr_q;
  logic signed [MW-1:0] pi_q;
  logic                 v_q;

  assign x_minus_y = (XW+1)'(x_i) - (XW+1)'(y_i);
  assign c_minus_s = (TW+1)'(c_i) - (TW+1)'(s_i);
  assign c_plus_s  = (TW+1)'(c_i) + (TW+1)'(s_i);

  // stage A: the three real products, sharing Z = C*(X-Y)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= '0;
      pr_q <= '0;
      pi_q <= '0;
      v_q  <= 1'b0;
    end else begin
      z_q  <= smul(MW'(x_minus_y), MW'(c_i));
      pr_q <= smul(MW'(y_i), MW'(c_minus_s));
      pi_q <= smul(MW'(x_i), MW'(c_plus_s));
      v_q  <= v_i;
    end
  end

  // stage B: recombine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_o <= '0;
      im_o <= '0;
      v_o  <= 1'b0;
    end else begin
      re_o <= PW'(pr_q) + PW'(z_q);
      im_o <= PW'(pi_q) - PW'(z_q);
      v_o  <= v_q;
    end
  end

  // four-multiplier form of the same product, brought out for the checks
  logic signed [PW-1:0] chk_re;
  logic signed [PW-1:0] chk_im;
  assign chk_re = PW'(x_i) * PW'(c_i) - PW'(y_i) * PW'(s_i);
  assign chk_im = PW'(x_i) * PW'(s_i) + PW'(y_i) * PW'(c_i);

  p_cmul_re_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (re_o == $past(chk_re, 2)));
  p_cmul_im_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (im_o == $past(chk_im, 2)));

endmodule

// File: rtl/bfly_rne.sv
module bfly_rne #(
  parameter int IW = 31,
  parameter int OW = 14,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] val,
  input  logic [SW-1:0]        sh,
  output logic signed [OW-1:0] res
);

  function automatic logic signed [IW:0] rne(input logic signed [IW-1:0] v,
                                             input logic [SW-1:0] s);
    logic signed [IW:0] q;
    logic [IW-1:0]      msk;
    logic [IW-1:0]      rem;
    logic [IW-1:0]      half;
    q    = (IW+1)'(v) >>> s;
    msk  = (IW'(1) << s) - IW'(1);
    rem  = $unsigned(v) & msk;
    half = (IW'(1) << s) >> 1;
    if ((s != '0) && ((rem > half) || ((rem == half) && q[0])))
      q = q + (IW+1)'(1);
    return q;
  endfunction

  assign res = OW'(rne(val, sh));

  // twice the rounding error, and the step size, for the checks
  logic signed [IW+2:0] err2;
  logic signed [IW+2:0] span;
  assign err2 = (((IW+3)'(res) <<< sh) - (IW+3)'(val)) <<< 1;
  assign span = (IW+3)'(1) <<< sh;

  // R6 and R9: within half a step, so the narrowed result did not wrap
  p_round_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err2 <= span) && (err2 >= -span));
  p_round_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((err2 == span) || (err2 == -span)) |-> !res[0]);

endmodule

// File: rtl/bfly_dif_r2.sv
module bfly_dif_r2 #(
  parameter int DW   = 12,
  parameter int TW   = 16,
  parameter int NPTS = 16,
  parameter bfly_pkg::scale_mode_e SCALE_MODE = bfly_pkg::SCL_PORT,
  localparam int AW = $clog2(NPTS / 2),
  localparam int OW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic [AW-1:0]        tw_addr,
  input  logic                 scale_in,
  output logic                 out_valid,
  output logic signed [OW-1:0] up_re,
  output logic signed [OW-1:0] up_im,
  output logic signed [OW-1:0] lo_re,
  output logic signed [OW-1:0] lo_im
);
  import bfly_pkg::*;

  localparam int XW   = DW + 1;
  localparam int PW   = XW + TW + 2;
  localparam int FRAC = TW - 2;
  localparam int LSW  = $clog2(FRAC + 2);

  // scaling source
  logic scl_sel;
  if (SCALE_MODE == SCL_OFF) begin : g_scl_off
    assign scl_sel = 1'b0;
  end else if (SCALE_MODE == SCL_ON) begin : g_scl_on
    assign scl_sel = 1'b1;
  end else begin : g_scl_port
    assign scl_sel = scale_in;
  end

  // stage 1: sum and difference, twiddle read
  logic                 v1;
  logic                 scl1;
  logic signed [XW-1:0] sum1 [2];
  logic signed [XW-1:0] dif1 [2];
  logic signed [TW-1:0] c1;
  logic signed [TW-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      scl1    <= 1'b0;
      sum1[0] <= '0;
      sum1[1] <= '0;
      dif1[0] <= '0;
      dif1[1] <= '0;
    end else begin
      v1      <= in_valid;
      scl1    <= scl_sel;
      sum1[0] <= XW'(a_re) + XW'(b_re);
      sum1[1] <= XW'(a_im) + XW'(b_im);
      dif1[0] <= XW'(a_re) - XW'(b_re);
      dif1[1] <= XW'(a_im) - XW'(b_im);
    end
  end

  bfly_twiddle_rom #(.NPTS(NPTS), .TW(TW)) u_rom (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (tw_addr),
    .c_o  (c1),
    .s_o  (s1)
  );

  // stages 2 and 3: complex product on the difference
  logic                 v3;
  logic signed [PW-1:0] prod3 [2];

  bfly_cmul3 #(.XW(XW), .TW(TW)) u_cmul (
    .clk  (clk),
    .rst_n(rst_n),
    .v_i  (v1),
    .x_i  (dif1[0]),
    .y_i  (dif1[1]),
    .c_i  (c1),
    .s_i  (s1),
    .v_o  (v3),
    .re_o (prod3[0]),
    .im_o (prod3[1])
  );

  // matching delay for the sum path and the scale flag
  logic                 scl2;
  logic                 scl3;
  logic signed [XW-1:0] sum2 [2];
  logic signed [XW-1:0] sum3 [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl2 <= 1'b0;
      scl3 <= 1'b0;
    end else begin
      scl2 <= scl1;
      scl3 <= scl2;
    end
  end

  // stage 4: rounding and output registers, one lane per generate pass
  logic [LSW-1:0]       lo_sh;
  logic signed [OW-1:0] up_rnd [2];
  logic signed [OW-1:0] lo_rnd [2];
  logic signed [OW-1:0] up_q   [2];
  logic signed [OW-1:0] lo_q   [2];

  assign lo_sh = LSW'(FRAC) + LSW'(scl3);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum2[g] <= '0;
        sum3[g] <= '0;
        up_q[g] <= '0;
        lo_q[g] <= '0;
      end else begin
        sum2[g] <= sum1[g];
        sum3[g] <= sum2[g];
        up_q[g] <= up_rnd[g];
        lo_q[g] <= lo_rnd[g];
      end
    end

    bfly_rne #(.IW(XW), .OW(OW), .SW(1)) u_rnd_up (
      .clk  (clk),
      .rst_n(rst_n),
      .val  (sum3[g]),
      .sh   (scl3),
      .res  (up_rnd[g])
    );

    bfly_rne #(.IW(PW), .OW(OW), .SW(LSW)) u_rnd_lo (
      .clk  (clk),
      .rst_n(rst_n),
      .val  (prod3[g]),
      .sh   (lo_sh),
      .res  (lo_rnd[g])
    );
  end

  logic v4;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v4 <= 1'b0;
    else        v4 <= v3;
  end

  assign out_valid = v4;
  assign up_re     = up_q[0];
  assign up_im     = up_q[1];
  assign lo_re     = lo_q[0];
  assign lo_im     = lo_q[1];

  // edges since reset release, saturating, so the latency check only looks back after reset
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (up_re == '0) && (lo_re == '0)));

endmodule

// File: tb/tb_bfly_dif_r2.sv
module tb_bfly_dif_r2;
  import bfly_pkg::*;

  localparam int CLK_NS = 10;
  localparam int DW     = 12;
  localparam int TW     = 16;
  localparam int NPTS   = 16;
  localparam int AW     = $clog2(NPTS / 2);
  localparam int OW     = DW + 2;
  localparam int FRAC   = TW - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic scale_in = 1'b0;
  logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic [AW-1:0] tw_addr = '0;
  logic out_valid;
  logic signed [OW-1:0] up_re, up_im, lo_re, lo_im;

  always #(CLK_NS / 2) clk = ~clk;

  bfly_dif_r2 #(.DW(DW), .TW(TW), .NPTS(NPTS), .SCALE_MODE(SCL_PORT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .tw_addr(tw_addr), .scale_in(scale_in),
    .out_valid(out_valid), .up_re(up_re), .up_im(up_im),
    .lo_re(lo_re), .lo_im(lo_im)
  );

  int n_chk = 0;
  int n_fail = 0;

  // expected results waiting in flight, slot 3 is due now
  bit     e_v   [4];
  longint e_ur  [4];
  longint e_ui  [4];
  longint e_lr  [4];
  longint e_li  [4];
  string  e_tag [4];

  // floor division by 2^s, then ties to the even neighbour
  function automatic longint ref_round(input longint v, input int s);
    longint p, q, r;
    if (s == 0) return v;
    p = 64'sd1 <<< s;
    q = v / p;
    if ((v % p != 0) && (v < 0)) q = q - 1;
    r = v - q * p;
    if ((2 * r > p) || ((2 * r == p) && (q[0] == 1'b1))) q = q + 1;
    return q;
  endfunction

  // R3 table value: cosine, or negated sine, rounded away from zero on ties
  function automatic longint ref_tw(input int k, input bit want_s);
    real th, x, sc;
    th = 2.0 * 3.14159265358979323846 * real'(k) / real'(NPTS);
    x  = want_s ? -$sin(th) : $cos(th);
    sc = x * (2.0 ** FRAC);
    if (sc >= 0.0) return longint'($floor(sc + 0.5));
    return -longint'($floor(-sc + 0.5));
  endfunction

  function automatic longint rnd_op();
    return longint'($urandom % (32'd1 << DW)) - (64'sd1 <<< (DW - 1));
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input longint ar, input longint ai, input longint br,
                      input longint bi, input int k, input bit sc, input string tag);
    longint c, s, dr, di;
    @(negedge clk);
    check("R7", "out_valid", longint'(out_valid), longint'(e_v[3]));
    if (e_v[3] && out_valid) begin
      check({e_tag[3], " R1"}, "upper re", longint'(up_re), e_ur[3]);
      check({e_tag[3], " R1"}, "upper im", longint'(up_im), e_ui[3]);
      check({e_tag[3], " R2"}, "lower re", longint'(lo_re), e_lr[3]);
      check({e_tag[3], " R2"}, "lower im", longint'(lo_im), e_li[3]);
    end
    for (int i = 3; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_ur[i] = e_ur[i-1]; e_ui[i] = e_ui[i-1];
      e_lr[i] = e_lr[i-1]; e_li[i] = e_li[i-1]; e_tag[i] = e_tag[i-1];
    end
    c  = ref_tw(k, 1'b0);
    s  = ref_tw(k, 1'b1);
    dr = ar - br;
    di = ai - bi;
    e_v[0]   = v;
    e_tag[0] = tag;
    e_ur[0]  = ref_round(ar + br, int'(sc));
    e_ui[0]  = ref_round(ai + bi, int'(sc));
    e_lr[0]  = ref_round(dr * c - di * s, FRAC + int'(sc));
    e_li[0]  = ref_round(dr * s + di * c, FRAC + int'(sc));
    in_valid = v;
    a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
    tw_addr  = AW'(k);
    scale_in = sc;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint mx, mn;
    int unsigned seed_v;
    int tie_vals [7] = '{1, 3, 5, 7, -1, -3, -5};
    seed_v = $urandom(32'd20511);
    mx = (64'sd1 <<< (DW - 1)) - 1;
    mn = -(64'sd1 <<< (DW - 1));
    for (int i = 0; i < 4; i++) begin
      e_v[i] = 1'b0; e_ur[i] = 0; e_ui[i] = 0; e_lr[i] = 0; e_li[i] = 0; e_tag[i] = "idle";
    end

    // R8: quiet outputs under reset, even with inputs active
    in_valid = 1'b1; a_re = 12'sd100; b_re = 12'sd7;
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", longint'(out_valid), 0);
    check("R8", "up_re in reset", longint'(up_re), 0);
    check("R8", "lo_im in reset", longint'(lo_im), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R3: every table entry, both scale settings
    for (int k = 0; k < NPTS / 2; k++)
      for (int j = 0; j < 6; j++)
        step(1'b1, rnd_op(), rnd_op(), rnd_op(), rnd_op(), k, j[0], "R3 sweep");

    // R4: unity twiddle, odd differences give lower-path ties when shifting
    for (int j = -4; j <= 4; j++) begin
      step(1'b1, longint'(j), longint'(2 * j + 1), 0, 0, 0, 1'b1, "R4 unity tie R6");
      step(1'b1, longint'(j), longint'(-j), 0, 0, 0, 1'b0, "R4 unity");
    end
    // quarter turn: pure swap of lanes, ties again
    for (int j = -3; j <= 3; j++)
      step(1'b1, longint'(2 * j + 1), longint'(j), 0, 0, NPTS / 4, 1'b1, "R6 quarter tie");

    // R6: directed sum ties on the upper path
    foreach (tie_vals[i])
      step(1'b1, longint'(tie_vals[i]), longint'(tie_vals[i]), 0, 0, 0, 1'b1, "R6 sum tie");

    // R5: same operands with and without the shift
    for (int j = 0; j < 6; j++) begin
      longint p, q, r, t;
      p = rnd_op(); q = rnd_op(); r = rnd_op(); t = rnd_op();
      step(1'b1, p, q, r, t, j % (NPTS / 2), 1'b0, "R5 no shift");
      step(1'b1, p, q, r, t, j % (NPTS / 2), 1'b1, "R5 shift");
    end

    // R9: full-scale corners, including the 45-degree entry
    for (int k = 0; k < NPTS / 2; k++) begin
      step(1'b1, mx, mx, mn, mn, k, 1'b0, "R9 corner");
      step(1'b1, mx, mn, mn, mx, k, 1'b0, "R9 corner");
      step(1'b1, mn, mn, mn, mn, k, 1'b0, "R9 corner");
      step(1'b1, mx, mx, mx, mx, k, 1'b1, "R9 corner");
    end

    // R7: bubbles interleaved with random traffic
    for (int j = 0; j < 2500; j++)
      step(($urandom % 5) != 0, rnd_op(), rnd_op(), rnd_op(), rnd_op(),
           int'($urandom % (NPTS / 2)), 1'(($urandom % 2)), "R7 random");

    for (int j = 0; j < 6; j++) step(1'b0, 0, 0, 0, 0, 0, 1'b0, "idle");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule